// File: doc/BRIEF.md
# Claim/Complete External Interrupt Controller

This block gathers up to 31 level-sensitive interrupt lines for a single hart and turns them into one external interrupt request. It keeps two bitmaps. The pending map follows the source inputs. The in-service map records sources that software has taken but not yet finished. The request is raised at machine level and at supervisor level together, whenever some source is pending and not in service.

Software works through a 32-bit register bus. Reading the claim word returns the ID of the waiting source with the lowest number and marks that source in service. The read returns 0 if no source is waiting. Writing a source ID to the same word finishes that source, so that it can be claimed again while its line is still high. There are no priorities, enables or thresholds: order is given by the source number alone.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, both interrupt outputs are low, `bus_rvalid` is low, and a claim read returns 0.
- R2: The pending bit of source n is bit n-1 of the pending map. It is loaded from `src_i[n-1]` on every clock edge, so a level change on a source reaches the interrupt outputs after exactly one rising edge.
- R3: A read of offset 0x200004 (the claim word) returns n+1, where n is the lowest bit index set in (pending AND NOT in-service).
- R4: A claim read sets the in-service bit of the source it returns, in the cycle the read is accepted. Later claims skip that source, and it stays in service even after its source line drops.
- R5: A claim read returns 0 and changes no state when (pending AND NOT in-service) is zero.
- R6: A write of value v to offset 0x200004 (the complete word) clears in-service bit v-1 when v is between 1 and 31. If that source is still high, the interrupt request rises again after the write.
- R7: A complete write with v = 0 or v >= 32 has no effect on the in-service map.
- R8: A read of offset 0x200000 returns 0 and has no side effect. Reads of any other offset also return 0, and writes to offsets other than 0x200004 change nothing.
- R9: `irq_mach_o` and `irq_super_o` are always equal. They are high exactly when (pending AND NOT in-service) is nonzero.
- R10: The data of a read is registered. `bus_rvalid` is high for exactly one cycle, the cycle after a read is accepted, and `bus_rdata` holds the read value in that cycle. A write never raises `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 31 | Source levels; bit n-1 is source ID n |
| bus_req | input | 1 | Bus transaction accepted in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Byte offset of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| irq_mach_o | output | 1 | Machine-level external interrupt request |
| irq_super_o | output | 1 | Supervisor-level external interrupt request |

## Verification
Each result has a fixed due time:
- A source level change reaches the interrupt outputs after one rising edge, through the pending register.
- Read data and `bus_rvalid` appear after the rising edge that accepts the read.
- The in-service change made by a claim or a complete shows on the outputs after that same edge.

The bench drives every stimulus on a falling edge and samples on the next falling edge, exactly one rising edge later. Before that edge it also checks that the interrupt outputs have not yet moved. Claim effects are observed through the following claim reads and through the interrupt outputs. In this way the effect of ignored complete values and stray offsets is shown through the bus and the interrupt lines, not through internal state.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int unsigned NUM_SRC_DEF = 31;
  localparam int unsigned ADDR_W_DEF  = 22;
  localparam int unsigned DATA_W      = 32;
  localparam logic [ADDR_W_DEF-1:0] CTX_BASE_DEF  = 22'h200000;
  localparam logic [ADDR_W_DEF-1:0] CLAIM_OFS_DEF = 22'h000004;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_CLAIM = 2'd1,
    ACC_CMPL  = 2'd2,
    ACC_OTHER = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/extint_src_sampler.sv
module extint_src_sampler #(
  parameter int unsigned NUM_SRC = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_d, pend_q;

  always_comb begin
    pend_d = src_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/extint_pick_lowest.sv
module extint_pick_lowest #(
  parameter int unsigned NUM_SRC = 31,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_SRC:0]   seen;
  logic [NUM_SRC-1:0] hit;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    assign hit[i]    = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (hit[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  assign any_o = seen[NUM_SRC];

  // R3: chosen index is requesting and nothing below it is
  a_r3_lowest_pick: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (req_i[idx_o] &&
      ((req_i & ((NUM_SRC'(1) << idx_o) - NUM_SRC'(1))) == '0)));
  a_r5_none_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |-> !any_o);
endmodule

// File: rtl/extint_served_tracker.sv
module extint_served_tracker #(
  parameter int unsigned NUM_SRC = 31,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               claim_fire_i,
  input  logic               claim_any_i,
  input  logic [IDX_W-1:0]   claim_idx_i,
  input  logic               cmpl_fire_i,
  input  logic               cmpl_ok_i,
  input  logic [IDX_W-1:0]   cmpl_idx_i,
  output logic [NUM_SRC-1:0] served_o
);
  logic [NUM_SRC-1:0] served_d, served_q;
  logic               served_en;

  always_comb begin
    served_d  = served_q;
    served_en = 1'b0;
    if (claim_fire_i && claim_any_i) begin
      served_d[claim_idx_i] = 1'b1;
      served_en = 1'b1;
    end else if (cmpl_fire_i && cmpl_ok_i) begin
      served_d[cmpl_idx_i] = 1'b0;
      served_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         served_q <= '0;
    else if (served_en) served_q <= served_d;
  end

  assign served_o = served_q;

  // R4: a claimed source is in service on the next cycle
  a_r4_claim_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_fire_i && claim_any_i) |=> served_q[$past(claim_idx_i)]);
  // R4: a claim never hands out a source already in service
  a_r4_not_twice: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_fire_i && claim_any_i) |-> !served_q[claim_idx_i]);
  // R6: a valid complete clears the bit
  a_r6_cmpl_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_fire_i && cmpl_ok_i && !claim_fire_i) |=> !served_q[$past(cmpl_idx_i)]);
  // R7: a rejected complete leaves the map alone
  a_r7_cmpl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_fire_i && !cmpl_ok_i && !claim_fire_i) |=> $stable(served_q));
endmodule

// File: rtl/extint_bus_port.sv
module extint_bus_port
  import extint_pkg::*;
#(
  parameter int unsigned NUM_SRC = 31,
  parameter int unsigned ADDR_W  = 22,
  parameter logic [ADDR_W-1:0] CTX_BASE  = 22'h200000,
  parameter logic [ADDR_W-1:0] CLAIM_OFS = 22'h000004,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              pick_any_i,
  input  logic [IDX_W-1:0]  pick_idx_i,
  output logic              claim_fire_o,
  output logic              cmpl_fire_o,
  output logic              cmpl_ok_o,
  output logic [IDX_W-1:0]  cmpl_idx_o,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam logic [ADDR_W-1:0] CLAIM_ADDR = CTX_BASE + CLAIM_OFS;

  acc_kind_e         kind;
  logic [DATA_W-1:0] id_m1;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rd_acc, rvalid_q;

  always_comb begin
    if (!bus_req)                 kind = ACC_NONE;
    else if (bus_addr != CLAIM_ADDR) kind = ACC_OTHER;
    else if (bus_we)              kind = ACC_CMPL;
    else                          kind = ACC_CLAIM;
  end

  assign rd_acc       = bus_req && !bus_we;
  assign claim_fire_o = (kind == ACC_CLAIM);
  assign cmpl_fire_o  = (kind == ACC_CMPL);
  assign id_m1        = bus_wdata - DATA_W'(1);
  assign cmpl_ok_o    = (id_m1 < DATA_W'(NUM_SRC));
  assign cmpl_idx_o   = id_m1[IDX_W-1:0];

  always_comb begin
    rdata_d = '0;
    if (kind == ACC_CLAIM && pick_any_i)
      rdata_d = DATA_W'(pick_idx_i) + DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_acc) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rd_acc;
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R5: an empty claim answers zero
  a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_fire_o && !pick_any_i) |=> (bus_rdata == '0));
  // R8: non-claim reads answer zero
  a_r8_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && kind == ACC_OTHER) |=> (bus_rdata == '0));
  // R10: rvalid follows an accepted read by one cycle
  a_r10_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> bus_rvalid);
  a_r10_no_wr_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |=> !bus_rvalid);
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int unsigned NUM_SRC = NUM_SRC_DEF,
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] CTX_BASE  = CTX_BASE_DEF,
  parameter logic [ADDR_W-1:0] CLAIM_OFS = CLAIM_OFS_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  output logic               irq_mach_o,
  output logic               irq_super_o
);
  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  logic [1:0]         rst_sync;
  logic               rst_q;
  logic [NUM_SRC-1:0] pend, served, waiting;
  logic               pick_any, claim_fire, cmpl_fire, cmpl_ok;
  logic [IDX_W-1:0]   pick_idx, cmpl_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  extint_src_sampler #(.NUM_SRC(NUM_SRC)) u_sampler (
    .clk(clk), .rst_n(rst_q), .src_i(src_i), .pend_o(pend));

  assign waiting = pend & ~served;

  extint_pick_lowest #(.NUM_SRC(NUM_SRC)) u_pick (
    .clk(clk), .rst_n(rst_q), .req_i(waiting),
    .any_o(pick_any), .idx_o(pick_idx));

  extint_served_tracker #(.NUM_SRC(NUM_SRC)) u_served (
    .clk(clk), .rst_n(rst_q),
    .claim_fire_i(claim_fire), .claim_any_i(pick_any), .claim_idx_i(pick_idx),
    .cmpl_fire_i(cmpl_fire), .cmpl_ok_i(cmpl_ok), .cmpl_idx_i(cmpl_idx),
    .served_o(served));

  extint_bus_port #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
    .CTX_BASE(CTX_BASE), .CLAIM_OFS(CLAIM_OFS)
  ) u_port (
    .clk(clk), .rst_n(rst_q),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata),
    .pick_any_i(pick_any), .pick_idx_i(pick_idx),
    .claim_fire_o(claim_fire), .cmpl_fire_o(cmpl_fire),
    .cmpl_ok_o(cmpl_ok), .cmpl_idx_o(cmpl_idx),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid));

  assign irq_mach_o  = pick_any;
  assign irq_super_o = pick_any;

  // R9: both request lines agree
  a_r9_lines_agree: assert property (@(posedge clk) disable iff (!rst_q)
    irq_mach_o == irq_super_o);
  // R2: a source high on the previous edge and not in service raises the line
  a_r2_level_reaches_irq: assert property (@(posedge clk) disable iff (!rst_q)
    (src_i[0] && !served[0]) |=> (irq_mach_o || served[0]));
  // R1: held reset keeps the outputs quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_q |-> (!irq_mach_o && !bus_rvalid));
endmodule

// File: tb/extint_ctrl_test.sv
module extint_ctrl_test;
  localparam logic [21:0] CTX   = 22'h200000;
  localparam logic [21:0] CLAIM = 22'h200004;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [30:0] src;
  logic        req, we;
  logic [21:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        rvalid, irq_m, irq_s;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  extint_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_req(req), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .bus_rvalid(rvalid),
    .irq_mach_o(irq_m), .irq_super_o(irq_s));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    chk({tag, " R9 irq_mach"}, {31'd0, irq_m}, {31'd0, exp});
    chk({tag, " R9 irq_super"}, {31'd0, irq_s}, {31'd0, exp});
  endtask

  task automatic bus_read(input logic [21:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    chk("R10 rvalid after read", {31'd0, rvalid}, 32'd1);
    d = rdata;
  endtask

  task automatic bus_write(input logic [21:0] a, input logic [31:0] v);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R10 no rvalid on write", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic claim_expect(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(CLAIM, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    chk_irq("R1 reset", 1'b0);
    chk("R1 rvalid reset", {31'd0, rvalid}, 32'd0);
    claim_expect("R1 claim after reset", 32'd0);
    @(negedge clk);
    chk("R10 rvalid one cycle", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_level;
    @(negedge clk);
    src[3] = 1'b1;
    #1;
    chk_irq("R2 before edge", 1'b0);
    @(negedge clk);
    chk_irq("R2 source high", 1'b1);
    src[3] = 1'b0;
    @(negedge clk);
    chk_irq("R2 source low", 1'b0);
  endtask

  task automatic t_order;
    @(negedge clk);
    src[2] = 1'b1; src[6] = 1'b1; src[30] = 1'b1;
    @(negedge clk);
    chk_irq("R9 three waiting", 1'b1);
    claim_expect("R3 first claim id3", 32'd3);
    claim_expect("R4 second claim id7", 32'd7);
    claim_expect("R4 third claim id31", 32'd31);
    chk_irq("R4 all in service", 1'b0);
    claim_expect("R5 empty claim", 32'd0);
    chk_irq("R5 empty claim no change", 1'b0);
  endtask

  task automatic t_complete;
    bus_write(CLAIM, 32'd7);
    chk_irq("R6 id7 again waiting", 1'b1);
    claim_expect("R6 reclaim id7", 32'd7);
    chk_irq("R6 after reclaim", 1'b0);
  endtask

  task automatic t_ignore;
    bus_write(CLAIM, 32'd0);
    chk_irq("R7 complete 0", 1'b0);
    bus_write(CLAIM, 32'd32);
    chk_irq("R7 complete 32", 1'b0);
    bus_write(CLAIM, 32'hFFFF_FFFF);
    chk_irq("R7 complete huge", 1'b0);
    claim_expect("R7 nothing released", 32'd0);
  endtask

  task automatic t_other;
    logic [31:0] d;
    @(negedge clk);
    src[0] = 1'b1;
    @(negedge clk);
    chk_irq("R8 id1 waiting", 1'b1);
    bus_read(CTX, d);
    chk("R8 context base reads 0", d, 32'd0);
    chk_irq("R8 base read no claim", 1'b1);
    bus_read(22'h000004, d);
    chk("R8 stray offset reads 0", d, 32'd0);
    bus_read(22'h200008, d);
    chk("R8 next offset reads 0", d, 32'd0);
    bus_write(CTX, 32'd3);
    bus_write(22'h000004, 32'd31);
    claim_expect("R8 claim still id1", 32'd1);
    claim_expect("R8 stray writes ignored", 32'd0);
    chk_irq("R8 all served", 1'b0);
  endtask

  task automatic t_drop;
    @(negedge clk);
    src[2] = 1'b0;
    @(negedge clk);
    chk_irq("R4 drop while served", 1'b0);
    bus_write(CLAIM, 32'd3);
    chk_irq("R6 complete dropped src", 1'b0);
    claim_expect("R4 dropped not claimable", 32'd0);
    @(negedge clk);
    src[2] = 1'b1;
    @(negedge clk);
    chk_irq("R2 source re-raised", 1'b1);
    claim_expect("R3 claim id3 again", 32'd3);
  endtask

  initial begin
    rst_n = 1'b0; src = '0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_level();
    t_order();
    t_complete();
    t_ignore();
    t_other();
    t_drop();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule